// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

This block is a memory-mapped system timer. A 32-bit counter advances by one on each clock cycle in which an external prescaler raises `tick_en`, and software can load it with any value. Four 32-bit compare registers are each checked for exact equality against the counter. When a channel's interrupt enable is set, an equality sets that channel's sticky status bit, and the matching interrupt line stays high until software clears the bit.

Channel 3 also acts as a watchdog. If the watchdog arm bit is set when channel 3 matches, the block raises a one-cycle reset request and clears the arm bit, so a second match does not request another reset unless software has armed the watchdog again. Registers are reached through a simple select/write bus. Read data comes back one cycle after the request. An unmapped read returns zero and flags an error.

Top module: `os_match_timer`

## Requirements
- R1: After reset the counter, all four compare registers, the interrupt-enable register, the watchdog arm bit and the status bits read as zero, and `irq` and `rst_req` are low.
- R2: On a write to offset 0x10 the counter takes the written value. Otherwise it increments by one on each cycle in which `tick_en` is high and holds when `tick_en` is low. It wraps from 0xFFFFFFFF to 0.
- R3: Channel n (compare register at offset 4*n) matches in the cycle after the counter has been loaded or incremented to the exact value of that register. If bit n of the interrupt enable is set, status bit n is set at the next clock edge and `irq[n]` goes high with it. A value behind the counter is reached after wrap-around.
- R4: If interrupt-enable bit n is clear, a channel-n match leaves status bit n and `irq[n]` unchanged.
- R5: A write to the status register (offset 0x14, bits 3:0) clears each bit that is written as 1 and is currently set, and drops the matching `irq` line. Writing 1 to a clear bit, or 0 to any bit, changes nothing.
- R6: A channel-3 match while the watchdog arm bit (offset 0x18, bit 0) is set drives `rst_req` high for exactly one cycle and clears the arm bit, whether or not interrupt-enable bit 3 is set. A channel-3 match with the arm bit clear requests nothing.
- R7: The interrupt-enable register (offset 0x1C) keeps only bits 11:0, and the watchdog register keeps only bit 0. All other bits read as zero.
- R8: A read returns its data on `bus_rdata` together with `bus_rvalid` in the cycle after the request. Compare registers read back the value last written to them.
- R9: Offset 0x20 reads as zero without an error. A read of any other offset outside the map, or of one that is not word-aligned, returns zero with `bus_rerr` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count enable from the prescaler |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rerr | output | 1 | One-cycle flag for an unmapped read |
| irq | output | 4 | Per-channel interrupt levels, one per status bit |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The compare path is driven with random compare values and random distances between the loaded start count and the target, and each run uses a random interrupt-enable word. This tells an exact-equality match apart from an off-by-one or a range compare, and shows that the enable bit of the matching channel is the one that gates it. A directed run stops one tick short of the target and checks that status is still clear, which separates "reached" from "about to reach". A load just below the wrap point checks the modulo arithmetic. Status writes with a 1 in a clear bit and with a 0 in a set bit separate the documented clear rule from plain overwrite. Two channel-3 matches in a row, with the arm bit set only before the first, show the one-shot disarm.

// File: rtl/omt_pkg.sv
package omt_pkg;
  // register byte offsets; compare registers sit at 4*n from zero
  localparam logic [7:0] OFF_CNT  = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h14;
  localparam logic [7:0] OFF_WDEN = 8'h18;
  localparam logic [7:0] OFF_IEN  = 8'h1C;
  localparam logic [7:0] OFF_SNAP = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_CNT,
    SEL_STAT,
    SEL_WDEN,
    SEL_IEN,
    SEL_SNAP
  } reg_sel_e;
endpackage

// File: rtl/omt_rst_sync.sv
module omt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/omt_counter.sv
module omt_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt,
  output logic          cnt_upd
);
  logic [DW-1:0] cnt_n;
  logic          upd_n;

  always_comb begin
    cnt_n = cnt;
    upd_n = 1'b0;
    if (ld_en) begin
      cnt_n = ld_val;
      upd_n = 1'b1;
    end else if (tick_en) begin
      cnt_n = cnt + DW'(1);
      upd_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cnt_upd <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      cnt_upd <= upd_n;
    end
  end

  // R2
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld_en) |=> (cnt == $past(cnt) + DW'(1)));
  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt == $past(ld_val)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_en) |=> $stable(cnt));
endmodule

// File: rtl/omt_chan.sv
module omt_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_val,
  input  logic [DW-1:0] cnt,
  input  logic          cnt_upd,
  output logic [DW-1:0] match_val,
  output logic          hit
);
  logic [DW-1:0] match_n;

  always_comb begin
    match_n = match_val;
    if (wr_en) match_n = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_val <= '0;
    else        match_val <= match_n;
  end

  // only a counter that has just moved can produce a hit
  assign hit = cnt_upd && (cnt == match_val);

  // R8
  match_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (match_val == $past(wr_val)));
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int NCH   = 4,
  parameter int IEN_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rvalid,
  output logic           bus_rerr,
  output logic [NCH-1:0] irq,
  output logic           rst_req
);
  import omt_pkg::*;

  localparam int WDOG_CH = NCH - 1;
  localparam int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1;

  logic srst_n;

  omt_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  // ---------------- decode ----------------
  reg_sel_e          sel;
  logic [IDX_W-1:0]  ch_idx;
  logic [AW-1:0]     off;

  always_comb begin
    off    = bus_addr;
    sel    = SEL_NONE;
    ch_idx = bus_addr[IDX_W+1:2];
    if (off[1:0] == 2'b00) begin
      if ((off >> 2) < AW'(NCH))        sel = SEL_MATCH;
      else if (off == AW'(OFF_CNT))     sel = SEL_CNT;
      else if (off == AW'(OFF_STAT))    sel = SEL_STAT;
      else if (off == AW'(OFF_WDEN))    sel = SEL_WDEN;
      else if (off == AW'(OFF_IEN))     sel = SEL_IEN;
      else if (off == AW'(OFF_SNAP))    sel = SEL_SNAP;
    end
  end

  logic wr_go, rd_go;
  assign wr_go = bus_sel && bus_wr;
  assign rd_go = bus_sel && !bus_wr;

  // ---------------- counter ----------------
  logic [DW-1:0] cnt;
  logic          cnt_upd;

  omt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(srst_n), .tick_en(tick_en),
    .ld_en(wr_go && (sel == SEL_CNT)), .ld_val(bus_wdata),
    .cnt(cnt), .cnt_upd(cnt_upd)
  );

  // ---------------- compare channels ----------------
  logic [DW-1:0]  match_val [NCH];
  logic [NCH-1:0] hit_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    omt_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(srst_n),
      .wr_en(wr_go && (sel == SEL_MATCH) && (ch_idx == IDX_W'(g))),
      .wr_val(bus_wdata), .cnt(cnt), .cnt_upd(cnt_upd),
      .match_val(match_val[g]), .hit(hit_vec[g])
    );
  end

  // ---------------- control / status state ----------------
  logic [NCH-1:0]   st_q, st_n, st_clr;
  logic [IEN_W-1:0] ien_q, ien_n;
  logic             wden_q, wden_n;
  logic             rreq_n;

  always_comb begin
    st_clr = '0;
    if (wr_go && (sel == SEL_STAT)) st_clr = bus_wdata[NCH-1:0] & st_q;
    st_n = (st_q & ~st_clr) | (hit_vec & ien_q[NCH-1:0]);

    ien_n = ien_q;
    if (wr_go && (sel == SEL_IEN)) ien_n = bus_wdata[IEN_W-1:0];

    rreq_n = hit_vec[WDOG_CH] && wden_q;
    wden_n = wden_q;
    if (rreq_n)                          wden_n = 1'b0;
    else if (wr_go && (sel == SEL_WDEN)) wden_n = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q    <= '0;
      ien_q   <= '0;
      wden_q  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      st_q    <= st_n;
      ien_q   <= ien_n;
      wden_q  <= wden_n;
      rst_req <= rreq_n;
    end
  end

  assign irq = st_q;

  // ---------------- read path ----------------
  logic [DW-1:0] rd_n;
  logic          rerr_n;

  always_comb begin
    rd_n   = '0;
    rerr_n = 1'b0;
    unique case (sel)
      SEL_MATCH: rd_n = match_val[ch_idx];
      SEL_CNT:   rd_n = cnt;
      SEL_STAT:  rd_n = DW'(st_q);
      SEL_WDEN:  rd_n = DW'(wden_q);
      SEL_IEN:   rd_n = DW'(ien_q);
      SEL_SNAP:  rd_n = '0;
      default:   rerr_n = 1'b1;
    endcase
    if (!rd_go) begin
      rd_n   = '0;
      rerr_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_rerr   <= 1'b0;
    end else begin
      bus_rdata  <= rd_n;
      bus_rvalid <= rd_go;
      bus_rerr   <= rerr_n;
    end
  end

  // R3 R4: a status bit only rises after an enabled hit
  stat_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q & ~$past(st_q) & ~$past(hit_vec & ien_q[NCH-1:0])) == '0);
  // R6
  wdog_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |=> !rst_req);
  // R6
  wdog_disarm_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |-> !wden_q);
  // R9
  rerr_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bus_rerr |-> (bus_rdata == '0));
  // R9
  rerr_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bus_rerr |-> bus_rvalid);
endmodule

// File: tb/os_match_timer_tb_top.sv
module os_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_rerr;
  logic [3:0]  irq;
  logic        rst_req;

  int total = 0;
  int bad   = 0;
  int rr_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  os_match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_rerr(bus_rerr), .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_req) rr_cnt++;

  function automatic logic [31:0] exp_ien(input logic [31:0] w);
    return w & 32'h0000_0FFF;
  endfunction

  function automatic logic [31:0] exp_stat(input logic [31:0] ien, input int ch);
    return ien[ch] ? (32'd1 << ch) : 32'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e, output logic v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata; e = bus_rerr; v = bus_rvalid;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e, v;
    logic [31:0] mv [4];
    void'($urandom(32'd2718));
    rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 rst_req", 32'(rst_req), 32'd0);
    rd(8'h10, d, e, v); chk("R1 counter", d, 32'd0);
    chk("R8 rvalid", 32'(v), 32'd1);
    for (int i = 0; i < 4; i++) begin
      rd(8'(4*i), d, e, v); chk("R1 match", d, 32'd0);
    end
    rd(8'h1C, d, e, v); chk("R1 ien", d, 32'd0);
    rd(8'h18, d, e, v); chk("R1 wden", d, 32'd0);
    rd(8'h14, d, e, v); chk("R1 status", d, 32'd0);

    // R7 masks
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, d, e, v); chk("R7 ien mask", d, exp_ien(32'hFFFF_FFFF));
    wr(8'h18, 32'hFFFF_FFFE);
    rd(8'h18, d, e, v); chk("R7 wden bit0 only", d, 32'd0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d, e, v); chk("R7 wden", d, 32'd1);
    wr(8'h18, 32'd0);
    wr(8'h1C, 32'd0);

    // R8 readback, R9 map edges
    for (int i = 0; i < 4; i++) begin
      mv[i] = $urandom;
      wr(8'(4*i), mv[i]);
    end
    for (int i = 0; i < 4; i++) begin
      rd(8'(4*i), d, e, v); chk("R8 match readback", d, mv[i]);
    end
    rd(8'h20, d, e, v); chk("R9 snapshot zero", d, 32'd0); chk("R9 snapshot no err", 32'(e), 32'd0);
    rd(8'h24, d, e, v); chk("R9 unmapped data", d, 32'd0); chk("R9 unmapped err", 32'(e), 32'd1);
    idle(1); chk("R9 err one cycle", 32'(bus_rerr), 32'd0);
    rd(8'h02, d, e, v); chk("R9 unaligned err", 32'(e), 32'd1);

    // R2 load, count, wrap, hold
    wr(8'h10, 32'hFFFF_FFFE);
    tick(3);
    rd(8'h10, d, e, v); chk("R2 wrap", d, 32'd1);
    idle(5);
    rd(8'h10, d, e, v); chk("R2 hold", d, 32'd1);

    // R3 directed: one short, then reach
    wr(8'h1C, 32'h1);
    wr(8'h00, 32'd100);
    wr(8'h10, 32'd90);
    tick(9); idle(1);
    rd(8'h14, d, e, v); chk("R3 not yet", d, 32'd0);
    tick(1); idle(1);
    chk("R3 irq0", 32'(irq), 32'h1);
    rd(8'h14, d, e, v); chk("R3 status0", d, 32'h1);

    // R5 clear rule
    wr(8'h14, 32'hE);
    rd(8'h14, d, e, v); chk("R5 one on clear bit", d, 32'h1);
    wr(8'h14, 32'h0);
    rd(8'h14, d, e, v); chk("R5 zero write", d, 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h14, d, e, v); chk("R5 cleared", d, 32'h0);
    chk("R5 irq low", 32'(irq), 32'h0);

    // R3 wrap-around: compare value behind the counter
    wr(8'h00, 32'd5);
    wr(8'h10, 32'hFFFF_FFFD);
    tick(8); idle(1);
    rd(8'h14, d, e, v); chk("R3 after wrap", d, 32'h1);
    wr(8'h14, 32'hF);

    // R4 disabled channel
    wr(8'h1C, 32'h0);
    wr(8'h04, 32'd50);
    wr(8'h10, 32'd45);
    tick(5); idle(1);
    rd(8'h14, d, e, v); chk("R4 status", d, 32'd0);
    chk("R4 irq", 32'(irq), 32'd0);

    // R6 watchdog one shot
    wr(8'h0C, 32'd200);
    wr(8'h18, 32'd1);
    wr(8'h10, 32'd195);
    tick(5); idle(2);
    chk("R6 pulse count", 32'(rr_cnt), 32'd1);
    rd(8'h18, d, e, v); chk("R6 disarmed", d, 32'd0);
    rd(8'h14, d, e, v); chk("R6 no status with ien3 clear", d, 32'd0);
    wr(8'h10, 32'd195);
    tick(5); idle(2);
    chk("R6 no second pulse", 32'(rr_cnt), 32'd1);

    // R3/R4 random compare runs
    for (int it = 0; it < 24; it++) begin
      int ch;
      int k;
      logic [31:0] m, iv;
      ch = int'($urandom % 4);
      k  = 1 + int'($urandom % 30);
      m  = $urandom;
      iv = $urandom & 32'hFFF;
      for (int j = 0; j < 4; j++) wr(8'(4*j), (j == ch) ? m : (m ^ 32'h8000_0000));
      wr(8'h1C, iv);
      wr(8'h14, 32'hF);
      wr(8'h10, m - 32'(k));
      tick(k); idle(1);
      rd(8'h14, d, e, v); chk("R3 R4 random status", d, exp_stat(iv, ch));
      chk("R3 random irq", 32'(irq), exp_stat(iv, ch));
      rd(8'h10, d, e, v); chk("R2 random count", d, m);
    end
    chk("R6 quiet in random", 32'(rr_cnt), 32'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule